// File: doc/BRIEF.md
# Bus-Sourced Arithmetic and Logic Unit

This block sits on an 8-bit shared data bus and holds two operand registers, A and B. Each register captures the bus value on a clock edge when its own load strobe is high. From the two held operands the block forms five results at once: the sum, the bitwise AND, OR and XOR, and A shifted right by one place.

There is no operation code. Each result is a separate bus source with its own output enable, so the instruction's source field picks the operator directly. A typical sequence is three instructions: load A, load B, then enable one result onto the bus. The selected result is registered and presented with a drive-valid flag. With no enable active the block drives zero and the flag is low.

Top module: `alu_bus_unit`

## Requirements
- R1: While rst is high at a clock edge, A and B become zero and drv_valid and drv_data become zero at that edge.
- R2: When ld_a is high at a clock edge, A takes the value on bus_in at that edge; B is unchanged.
- R3: When ld_b is high at a clock edge, B takes the value on bus_in at that edge; A is unchanged.
- R4: When a load strobe is low, its register holds its value whatever bus_in carries.
- R5: Enable bit 0 of src_en selects the sum A+B truncated to 8 bits; the carry out is dropped.
- R6: Enable bit 1 of src_en selects A AND B.
- R7: Enable bit 2 of src_en selects A OR B.
- R8: Enable bit 3 of src_en selects A XOR B.
- R9: Enable bit 4 of src_en selects A shifted right by one with a zero entering bit 7; B has no effect on it.
- R10: The selected result appears on drv_data, with drv_valid high, one clock edge after the enable is sampled, computed from the A and B held before that edge (a load in the same cycle does not affect it).
- R11: When no bit of src_en is high at an edge, drv_valid is low and drv_data is zero after that edge.
- R12: At most one bit of src_en may be high in any cycle; more than one is a usage error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Data from the shared bus |
| ld_a | input | 1 | Load strobe for operand A |
| ld_b | input | 1 | Load strobe for operand B |
| src_en | input | 5 | One-hot result enables: 0 add, 1 AND, 2 OR, 3 XOR, 4 shift right |
| drv_data | output | 8 | Registered result driven to the bus |
| drv_valid | output | 1 | High when drv_data carries a selected result |

## Verification
A load takes effect at the edge where its strobe is sampled, and a result is due one edge after its enable is sampled, so every stimulus cycle has exactly one expected output in the following cycle. The bench drives each cycle's inputs on the falling edge, pushes the expected drive value and flag for that cycle into a queue, and a monitor pops one item a short delay after every rising edge. Same-cycle load and enable cases check that the result uses the operands held before the edge.

// File: rtl/alu_bus_pkg.sv
package alu_bus_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_SRC = 5;

  typedef enum int {
    SRC_ADD = 0,
    SRC_AND = 1,
    SRC_OR  = 2,
    SRC_XOR = 3,
    SRC_SHR = 4
  } src_idx_e;
endpackage

// File: rtl/alu_operand_reg.sv
module alu_operand_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/alu_operator_bank.sv
module alu_operator_bank #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic [W-1:0]        op_a,
  input  logic [W-1:0]        op_b,
  output logic [N-1:0][W-1:0] res
);
  import alu_bus_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_op
    if (i == SRC_ADD) begin : g_add
      logic [W:0] full_sum;
      assign full_sum = {1'b0, op_a} + {1'b0, op_b};
      assign res[i]   = full_sum[W-1:0];
    end else if (i == SRC_AND) begin : g_and
      assign res[i] = op_a & op_b;
    end else if (i == SRC_OR) begin : g_or
      assign res[i] = op_a | op_b;
    end else if (i == SRC_XOR) begin : g_xor
      assign res[i] = op_a ^ op_b;
    end else if (i == SRC_SHR) begin : g_shr
      assign res[i] = {1'b0, op_a[W-1:1]};
    end else begin : g_none
      assign res[i] = '0;
    end
  end
endmodule

// File: rtl/alu_source_select.sv
module alu_source_select #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        en,
  input  logic [N-1:0][W-1:0] res,
  output logic [W-1:0]        data_q,
  output logic                valid_q
);
  logic [W-1:0] pick;
  logic         any;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en[i]) begin
        pick = res[i];
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= pick;
      valid_q <= any;
    end
  end
endmodule

// File: rtl/alu_bus_unit.sv
module alu_bus_unit #(
  parameter int W = alu_bus_pkg::DATA_W,
  parameter int N = alu_bus_pkg::NUM_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_in,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic [N-1:0] src_en,
  output logic [W-1:0] drv_data,
  output logic         drv_valid
);
  logic [W-1:0]        a_q;
  logic [W-1:0]        b_q;
  logic [N-1:0][W-1:0] results;

  alu_operand_reg #(.W(W)) u_reg_a (
    .clk(clk), .rst(rst), .load(ld_a), .din(bus_in), .q(a_q)
  );

  alu_operand_reg #(.W(W)) u_reg_b (
    .clk(clk), .rst(rst), .load(ld_b), .din(bus_in), .q(b_q)
  );

  alu_operator_bank #(.W(W), .N(N)) u_ops (
    .op_a(a_q), .op_b(b_q), .res(results)
  );

  alu_source_select #(.W(W), .N(N)) u_sel (
    .clk(clk), .rst(rst), .en(src_en), .res(results),
    .data_q(drv_data), .valid_q(drv_valid)
  );
endmodule

// File: rtl/alu_bus_unit_chk.sv
module alu_bus_unit_chk #(
  parameter int W = 8,
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] bus_in,
  input logic         ld_a,
  input logic         ld_b,
  input logic [N-1:0] src_en,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic [W-1:0] drv_data,
  input logic         drv_valid
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (a_q == '0 && b_q == '0 && !drv_valid && drv_data == '0));

  // R2
  load_a_chk: assert property (@(posedge clk) disable iff (rst)
    ld_a |=> a_q == $past(bus_in));

  // R4
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_a |=> $stable(a_q));

  // R4
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_b |=> $stable(b_q));

  // R5
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    src_en == 5'b00001 |=> drv_valid && drv_data == W'($past(a_q) + $past(b_q)));

  // R9
  shift_result_chk: assert property (@(posedge clk) disable iff (rst)
    src_en == 5'b10000 |=> drv_valid && drv_data == ($past(a_q) >> 1));

  // R11
  idle_drive_chk: assert property (@(posedge clk) disable iff (rst)
    src_en == '0 |=> !drv_valid && drv_data == '0);

  // R12
  one_source_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_en));
endmodule

bind alu_bus_unit alu_bus_unit_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .bus_in(bus_in), .ld_a(ld_a), .ld_b(ld_b),
  .src_en(src_en), .a_q(a_q), .b_q(b_q),
  .drv_data(drv_data), .drv_valid(drv_valid)
);

// File: tb/alu_bus_unit_tb.sv
module alu_bus_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_in = '0;
  logic       ld_a = 1'b0;
  logic       ld_b = 1'b0;
  logic [4:0] src_en = '0;
  logic [7:0] drv_data;
  logic       drv_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       valid;
    logic [7:0] data;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] m_a = '0;
  logic [7:0] m_b = '0;

  alu_bus_unit u_dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .ld_a(ld_a), .ld_b(ld_b),
    .src_en(src_en), .drv_data(drv_data), .drv_valid(drv_valid)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] model(input logic [4:0] en,
                                       input logic [7:0] a, input logic [7:0] b);
    case (en)
      5'b00001: return a + b;
      5'b00010: return a & b;
      5'b00100: return a | b;
      5'b01000: return a ^ b;
      5'b10000: return {1'b0, a[7:1]};
      default:  return 8'h00;
    endcase
  endfunction

  task automatic step(input logic la, input logic lb, input logic [7:0] d,
                      input logic [4:0] en, input string tag);
    exp_t e;
    @(negedge clk);
    ld_a = la; ld_b = lb; bus_in = d; src_en = en;
    e.valid = (en != 5'b0);
    e.data  = model(en, m_a, m_b);
    e.tag   = tag;
    sb.push_back(e);
    if (la) m_a = d;
    if (lb) m_b = d;
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (drv_valid !== e.valid || drv_data !== e.data) begin
        errors++;
        $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
                 e.tag, drv_valid, drv_data, e.valid, e.data);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (drv_valid !== 1'b0 || drv_data !== 8'h00) begin
      errors++;
      $display("FAIL R1: got valid=%0b data=%02h, expected valid=0 data=00",
               drv_valid, drv_data);
    end
    @(negedge clk); rst = 1'b0;
    step(0, 0, 8'hFF, 5'b00100, "R1");      // A|B after reset is zero
    step(0, 0, 8'hFF, 5'b00001, "R1");
    step(1, 0, 8'h3C, 5'b00000, "R11");     // R2 load A
    step(0, 0, 8'h77, 5'b00100, "R2");      // A|B = 3C, B still 0
    step(0, 1, 8'h0F, 5'b00000, "R11");     // R3 load B
    step(0, 0, 8'hAA, 5'b00010, "R3");      // 3C & 0F
    step(0, 0, 8'h55, 5'b00100, "R7");
    step(0, 0, 8'h99, 5'b01000, "R8");
    step(0, 0, 8'hEE, 5'b00001, "R4");      // bus ignored: 3C+0F
    step(1, 0, 8'hF0, 5'b00000, "R11");
    step(0, 1, 8'h25, 5'b00000, "R11");
    step(0, 0, 8'h00, 5'b00001, "R5");      // F0+25 = 115 -> 15
    step(0, 0, 8'h00, 5'b00010, "R6");
    step(0, 0, 8'h00, 5'b10000, "R9");      // F0 >> 1 = 78
    step(1, 0, 8'h81, 5'b00000, "R11");
    step(0, 1, 8'hFF, 5'b10000, "R9");      // B change, shift 81 -> 40
    step(0, 0, 8'h00, 5'b10000, "R9");
    step(0, 0, 8'h00, 5'b00001, "R5");      // 81+FF = 180 -> 80
    step(1, 1, 8'h12, 5'b01000, "R10");     // uses old A,B: 81^FF
    step(0, 0, 8'h00, 5'b01000, "R10");     // now 12^12 = 00
    step(0, 0, 8'h00, 5'b00001, "R10");     // 12+12 = 24
    step(0, 0, 8'h00, 5'b00000, "R11");
    step(0, 0, 8'h00, 5'b00000, "R11");
    @(negedge clk); src_en = '0; ld_a = 0; ld_b = 0;
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule